// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped GPIO controller. Its lines are split into banks of equal width, and each bank owns two 32-bit registers on a simple word bus: a latch that holds the value driven toward the pads, and a direction word. The bus is a select strobe, a write flag, an address and write data. Reads return data combinationally in the cycle of the access. Writes take effect on the next rising clock edge.

Bank registers are laid out on an 8-byte stride starting at 0x08. A 16-byte window at 0x90 is reserved for interrupt registers that live in a separate block. Every bank whose base would land in or past that window is pushed up by 0x10, so the decoder is not contiguous. Pad inputs pass through a two-stage synchronizer before software can read them. Software normally loads the output latch while a line is still an input, and only then turns the line around to an output.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted and right after it, every direction bit is 1, so all `padOe` bits are 0. Every output latch is 0, so all `padOut` bits are 0.
- R2: Bank b (b = 0 .. ceil(NUM_LINES/LINES_PER_BANK)-1) has a base address of (b+1)*8. Its data latch is at base+0 and its direction word is at base+4. Address bits [1:0] are ignored, so 0x0B reaches the bank-0 data latch.
- R3: A base of 0x90 or above is moved up by 0x10. With the defaults, bank 16 is at 0x88, bank 17 at 0xA0 and bank 18 at 0xA8. No address from 0x90 to 0x9F selects any bank.
- R4: `padOe[i]` is the inverse of direction bit i, where 1 means input and 0 means output. `padOut[i]` is always the latched value of line i.
- R5: A write to a data latch changes only that bank's latches, and a write to a direction word changes only that bank's direction bits. The new values appear on `padOut`/`padOe` one clock after the write edge.
- R6: A data latch can be written while its line is an input, and it keeps that value. Clearing the direction bit afterwards drives the stored value without any further write.
- R7: Reading a data latch returns the synchronized pad level for input lines and the latched value for output lines. A pad change becomes visible to reads after the second rising edge that samples it.
- R8: Read bits at and above LINES_PER_BANK, and bits of lines beyond NUM_LINES in the last bank, are 0. Writes to those bits are ignored.
- R9: An access to an address that selects no bank reads 0 and writes nothing. This covers the 0x90–0x9F window, address 0x00 and everything above the last bank.
- R10: `busRdata` is 0 whenever `busSel` is low or `busWrite` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access strobe for the current cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data; bits [LINES_PER_BANK-1:0] are used |
| busRdata | output | 32 | Read data, valid in the cycle of a read |
| padIn | input | NUM_LINES | Pad input levels, asynchronous |
| padOut | output | NUM_LINES | Output values toward the pads |
| padOe | output | NUM_LINES | Output enables, 1 = line driven |

## Verification
A pad level change and a direction write to the same line can land on the same clock. A data read in that window must choose between the synchronized pad level and the latch based on the new direction bit. The bench provokes this by toggling pads in the cycle where it flips direction words, then reading the bank. It also runs a long random phase that mixes writes, reads, hole addresses and pad noise. A behavioural per-line model in the bench updates on each edge, and every cycle it judges `busRdata`, `padOut` and `padOe` against that model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Reserved interrupt window that bank bases must skip
  localparam int unsigned HOLE_LO   = 32'h90;
  localparam int unsigned HOLE_SIZE = 32'h10;
  localparam int unsigned BANK_STRIDE = 8;

  typedef struct packed {
    logic hit;    // address selects some bank register
    logic isDir;  // selected register is the direction word
    logic wrStb;  // access is a write
  } gpioStrb_t;

  function automatic int unsigned bankBaseAddr(int unsigned b);
    int unsigned base;
    base = (b + 1) * BANK_STRIDE;
    if (base >= HOLE_LO) base = base + HOLE_SIZE;
    return base;
  endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NBANKS = 19,
  parameter int ADDR_W = 10,
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrb_t         strb,
  output logic [BANK_W-1:0] bankIdx
);

  logic [NBANKS-1:0] dataHit;
  logic [NBANKS-1:0] dirHit;
  logic [1:0]        unusedAddrLo;

  assign unusedAddrLo = busAddr[1:0];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(bankBaseAddr(b));
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(bankBaseAddr(b) + 4);
    assign dataHit[b] = busSel && (busAddr[ADDR_W-1:2] == DATA_A[ADDR_W-1:2]);
    assign dirHit[b]  = busSel && (busAddr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
  end

  always_comb begin
    bankIdx    = '0;
    strb.isDir = 1'b0;
    for (int b = 0; b < NBANKS; b++) begin
      if (dataHit[b] || dirHit[b]) begin
        bankIdx    = BANK_W'(b);
        strb.isDir = dirHit[b];
      end
    end
    strb.hit   = (|dataHit) || (|dirHit);
    strb.wrStb = busSel && busWrite;
  end

  // R2: at most one register of one bank decodes for any address
  p_onehot_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataHit, dirHit}));

  // R3: the reserved interrupt window never reaches a bank
  p_no_hole_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(HOLE_LO) && busAddr < ADDR_W'(HOLE_LO + HOLE_SIZE))
      |-> !strb.hit);

endmodule

// File: rtl/gpio_bank_store.sv
module gpio_bank_store
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES      = 150,
  parameter int LINES_PER_BANK = 8,
  parameter int BANK_W         = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  gpioStrb_t                 strb,
  input  logic [BANK_W-1:0]         bankIdx,
  input  logic [LINES_PER_BANK-1:0] wrBits,
  input  logic [NUM_LINES-1:0]      padIn,
  output logic [NUM_LINES-1:0]      padOut,
  output logic [NUM_LINES-1:0]      padOe,
  output logic [LINES_PER_BANK-1:0] rdBits
);

  logic [NUM_LINES-1:0] dataQ;
  logic [NUM_LINES-1:0] dirQ;
  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic                 bankWr;

  assign bankWr = strb.hit && strb.wrStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '1;
    end else if (bankWr) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (i / LINES_PER_BANK == int'(bankIdx)) begin
          if (strb.isDir) dirQ[i]  <= wrBits[i % LINES_PER_BANK];
          else            dataQ[i] <= wrBits[i % LINES_PER_BANK];
        end
      end
    end
  end

  // Two-stage synchronizer on the pad inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    rdBits = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i / LINES_PER_BANK == int'(bankIdx)) begin
        rdBits[i % LINES_PER_BANK] = strb.isDir ? dirQ[i]
                                   : (dirQ[i] ? syncB[i] : dataQ[i]);
      end
    end
  end

  assign padOut = dataQ;
  assign padOe  = ~dirQ;

  // R5: a data-latch write leaves every direction bit alone
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bankWr && !strb.isDir) |=> $stable(dirQ));

  // R5: a direction write leaves every data latch alone
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bankWr && strb.isDir) |=> $stable(dataQ));

  // R9: without a decoded write nothing stored changes
  p_no_stray_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bankWr |=> ($stable(dataQ) && $stable(dirQ)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES      = 150,
  parameter int LINES_PER_BANK = 8,
  parameter int ADDR_W         = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  localparam int NBANKS = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK;
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  gpioStrb_t                 strb;
  logic [BANK_W-1:0]         bankIdx;
  logic [LINES_PER_BANK-1:0] rdBits;
  logic [31-LINES_PER_BANK:0] unusedWdataHi;

  assign unusedWdataHi = busWdata[31:LINES_PER_BANK];

  gpio_bank_decode #(
    .NBANKS (NBANKS),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .bankIdx  (bankIdx)
  );

  gpio_bank_store #(
    .NUM_LINES      (NUM_LINES),
    .LINES_PER_BANK (LINES_PER_BANK),
    .BANK_W         (BANK_W)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bankIdx (bankIdx),
    .wrBits  (busWdata[LINES_PER_BANK-1:0]),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdBits  (rdBits)
  );

  assign busRdata = (strb.hit && !busWrite) ? 32'(rdBits) : 32'd0;

  // R10: an idle bus or a write cycle returns zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWrite) |-> (busRdata == 32'd0));

  // R8: bits above the bank width never read as one
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:LINES_PER_BANK] == '0);

endmodule

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;

  localparam int NL  = 150;
  localparam int LPB = 8;
  localparam int AW  = 10;
  localparam int NB  = (NL + LPB - 1) / LPB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] padIn = '0;
  logic [NL-1:0] padOut;
  logic [NL-1:0] padOe;

  // model state
  logic [NL-1:0] mData, mDir, mS1, mS2;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_bank_regs #(.NUM_LINES(NL), .LINES_PER_BANK(LPB), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe));

  function automatic int bankAt(int b);
    int base = (b + 1) * 8;
    if (base >= 144) base += 16;
    return base;
  endfunction

  // returns bank index or -1; kind 0 = data, 1 = direction
  function automatic int lookup(logic [AW-1:0] a, output int kind);
    kind = 0;
    for (int b = 0; b < NB; b++) begin
      if (int'(a >> 2) == bankAt(b) / 4) begin kind = 0; return b; end
      if (int'(a >> 2) == bankAt(b) / 4 + 1) begin kind = 1; return b; end
    end
    return -1;
  endfunction

  function automatic logic [31:0] expRead();
    logic [31:0] v = '0;
    int kind;
    int b;
    if (!busSel || busWrite) return 32'd0;
    b = lookup(busAddr, kind);
    if (b < 0) return 32'd0;
    for (int k = 0; k < LPB; k++) begin
      int ln = b * LPB + k;
      if (ln < NL) v[k] = (kind == 1) ? mDir[ln] : (mDir[ln] ? mS2[ln] : mData[ln]);
    end
    return v;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, busAddr, act, exp);
    end
  endtask

  task automatic checkVec(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(bit s, bit w, logic [AW-1:0] a, logic [31:0] d,
                      logic [NL-1:0] p, string tag);
    int kind;
    int b;
    @(negedge clk);
    busSel = s; busWrite = w; busAddr = a; busWdata = d; padIn = p;
    #1;
    check32((!s || w) ? "R10" : tag, busRdata, expRead());
    checkVec("R4 padOe", padOe, ~mDir);
    checkVec("R4 padOut", padOut, mData);
    @(posedge clk);
    if (s && w) begin
      b = lookup(a, kind);
      if (b >= 0)
        for (int k = 0; k < LPB; k++) begin
          int ln = b * LPB + k;
          if (ln < NL) begin
            if (kind == 1) mDir[ln] = d[k];
            else           mData[ln] = d[k];
          end
        end
    end
    mS2 = mS1;
    mS1 = p;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] p;
    logic [AW-1:0] addrList [16];
    mData = '0; mDir = '1; mS1 = '0; mS2 = '0;
    // R1: state held in reset
    repeat (2) @(negedge clk);
    checkVec("R1 padOe", padOe, '0);
    checkVec("R1 padOut", padOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    p = '0;

    // R1 read-back after reset: direction all ones, data zero (pads low)
    step(1, 0, 10'h00C, 0, p, "R1");
    step(1, 0, 10'h008, 0, p, "R1");
    // R6: load latch while still input, then turn lines around
    step(1, 1, 10'h008, 32'hA5, p, "R6");
    step(1, 0, 10'h008, 0, p, "R6");
    step(1, 1, 10'h00C, 32'hF0, p, "R6");
    step(1, 0, 10'h008, 0, p, "R6");
    // R2: low address bits ignored, direction word at +4
    step(1, 0, 10'h00B, 0, p, "R2");
    step(1, 0, 10'h00E, 0, p, "R2");
    // R7: pad pattern seen on input lines after two edges
    p[7:0] = 8'h3C;
    step(1, 0, 10'h008, 0, p, "R7");
    step(1, 0, 10'h008, 0, p, "R7");
    step(1, 0, 10'h008, 0, p, "R7");
    // R3: banks around the hole
    step(1, 1, 10'h088, 32'h11, p, "R3");
    step(1, 1, 10'h0A0, 32'h22, p, "R3");
    step(1, 1, 10'h0A4, 32'h0F, p, "R3");
    step(1, 0, 10'h0A0, 0, p, "R3");
    step(1, 0, 10'h088, 0, p, "R3");
    // R9: hole and unmapped writes have no effect
    step(1, 1, 10'h090, 32'hFF, p, "R9");
    step(1, 1, 10'h094, 32'h00, p, "R9");
    step(1, 1, 10'h098, 32'hFF, p, "R9");
    step(1, 1, 10'h09C, 32'h00, p, "R9");
    step(1, 1, 10'h000, 32'hFF, p, "R9");
    step(1, 1, 10'h3FC, 32'hFF, p, "R9");
    step(1, 0, 10'h090, 0, p, "R9");
    step(1, 0, 10'h0B0, 0, p, "R9");
    step(1, 0, 10'h0A4, 0, p, "R9");
    // R8: partial last bank and upper bits
    step(1, 1, 10'h0A8, 32'hFFFF_FFFF, p, "R8");
    step(1, 1, 10'h0AC, 32'hFFFF_FF00, p, "R8");
    step(1, 0, 10'h0A8, 0, p, "R8");
    step(1, 0, 10'h0AC, 0, p, "R8");
    // R5: data write leaves direction, direction write leaves data
    step(1, 1, 10'h010, 32'h5A, p, "R5");
    step(1, 0, 10'h014, 0, p, "R5");
    step(1, 1, 10'h014, 32'h00, p, "R5");
    step(1, 0, 10'h010, 0, p, "R5");
    // R7: pad change in the same cycle as a direction flip
    p[15:8] = 8'hC3;
    step(1, 1, 10'h014, 32'hF0, p, "R7");
    step(1, 0, 10'h010, 0, p, "R7");
    step(1, 0, 10'h010, 0, p, "R7");
    // R10: idle bus
    step(0, 0, 10'h008, 0, p, "R10");

    addrList = '{10'h008, 10'h00C, 10'h010, 10'h014, 10'h088, 10'h08C,
                 10'h090, 10'h098, 10'h0A0, 10'h0A4, 10'h0A8, 10'h0AC,
                 10'h000, 10'h0B0, 10'h04B, 10'h04E};
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      for (int k = 0; k < NL; k++) p[k] = 1'($urandom);
      a = (($urandom % 4) == 0) ? AW'($urandom) : addrList[$urandom % 16];
      step(1'($urandom % 8 != 0), 1'($urandom), a, $urandom, p, "R7");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule